// File: doc/BRIEF.md
# Address Translation Front-End with Fault Capture

This block takes one translation-miss request at a time and settles how its virtual address becomes a physical one. With translation switched off the address passes through unchanged. With translation on, privileged accesses to the lower half of the address space are redirected to the upper half without touching the page tables. Every other access, and every access from user mode, is sent to an external page-table walker. The block then waits for that walker's answer.

A successful outcome leaves as a single-cycle fill pulse. The pulse carries the page-aligned virtual and physical addresses, a permission mask and a page-size flag. A nonzero walker code leaves as a single-cycle fault pulse instead. That pulse tells an instruction trap apart from a data trap, and it loads the fault status and fault address registers. Those registers can be read at the ports. The walker and the translation cache are not part of the block.

Top module: `xlat_front`

## Requirements
- R1: With `xlat_on` low, the fill pulse comes one cycle after acceptance. Its physical address equals the virtual address, its permission mask is 3'b111 (bit 0 read, bit 1 write, bit 2 execute), `fill_big` is 0 (4 KB page), and no walk is started.
- R2: With `xlat_on` high, a request whose virtual address bit 31 is set, or whose `req_user` is high, produces a one-cycle `walk_go` pulse in the cycle after acceptance. During that pulse `walk_va`, `walk_kind` and `walk_user` show the request's own values.
- R3: With `xlat_on` high, a privileged request with virtual address bit 31 clear gets a fill one cycle after acceptance. Its physical address is the virtual address OR 0x80000000, its mask is 3'b111, `fill_big` is 0, and no walk is started.
- R4: The low 12 bits of `fill_va` and `fill_pa` are always zero. After a successful walk (code 0), the fill carries the walker's permission mask and size flag (1 = 4 MB page) in the cycle after the response.
- R5: A walker response with a nonzero code produces a fault pulse and no fill. From that cycle on, `flt_status` holds the code and `flt_addr` holds the full, unaligned virtual address.
- R6: `flt_itrap` is 1 during a fault pulse when the access kind was 2 (instruction fetch), and 0 for kinds 0 (load) and 1 (store).
- R7: `flt_status` and `flt_addr` reset to zero and change only with a fault pulse. Successful fills and ignored responses leave them unchanged.
- R8: `busy` is high from the cycle after acceptance up to the fill or fault pulse, and low in the pulse cycle. Requests presented while `busy` is high are ignored.
- R9: Fill and fault pulses last one cycle, never occur together, and occur exactly once per accepted request.
- R10: A walker response that arrives while no walk is outstanding produces no fill, no fault and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_on | input | 1 | Translation enable |
| req_valid | input | 1 | Miss request present; taken when `busy` is low |
| req_va | input | 32 | Virtual address of the miss |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| req_user | input | 1 | Access comes from user mode |
| busy | output | 1 | A request is in flight |
| walk_go | output | 1 | One-cycle walk start pulse |
| walk_va | output | 32 | Virtual address for the walker |
| walk_kind | output | 2 | Access kind for the walker |
| walk_user | output | 1 | User flag for the walker |
| wrsp_valid | input | 1 | Walker answer present |
| wrsp_code | input | 8 | 0 success, otherwise fault code |
| wrsp_pa | input | 32 | Physical address from the walker |
| wrsp_perm | input | 3 | Permission mask from the walker |
| wrsp_big | input | 1 | Walker found a 4 MB page |
| fill_valid | output | 1 | One-cycle fill pulse |
| fill_va | output | 32 | Page-aligned virtual address |
| fill_pa | output | 32 | Page-aligned physical address |
| fill_perm | output | 3 | Permission mask (bit 0 read, 1 write, 2 execute) |
| fill_big | output | 1 | 1 = 4 MB page, 0 = 4 KB page |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_itrap | output | 1 | 1 instruction trap, 0 data trap |
| flt_status | output | 8 | Last fault code |
| flt_addr | output | 32 | Virtual address of the last fault |

## Verification
The main routing decision is tried with four kinds of request. Translation off with bit 31 set or clear shows that identity mapping ignores the address half. A privileged low address under translation separates the redirect from a walk. A privileged high address and user addresses of both halves show that either condition alone starts a walk. Walker answers mix success with 4 KB and 4 MB sizes and unaligned physical addresses, and faults carry fetch and data kinds. These separate permission and size forwarding, alignment, and the trap kind. Directed cases cover a request held during a walk, a stray walker answer while idle, and a success after a fault, which must leave the fault registers untouched.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_RSVD  = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOCAL = 2'd1,
      ST_WALK  = 2'd2
   } state_e;

   localparam int PERM_W = 3;
   localparam logic [PERM_W-1:0] PERM_RWX = 3'b111;
endpackage

// File: rtl/xlat_route.sv
module xlat_route #(
   parameter int VA_W         = 32,
   parameter bit LOW_REDIRECT = 1'b1
) (
   input  logic            xlat_on,
   input  logic [VA_W-1:0] va,
   input  logic            user,
   output logic            need_walk,
   output logic [VA_W-1:0] local_pa
);
   localparam int TOP = VA_W - 1;

   generate
      if (LOW_REDIRECT) begin : g_redirect
         always_comb begin
            need_walk = xlat_on && (va[TOP] || user);
            local_pa  = xlat_on ? {1'b1, va[TOP-1:0]} : va;
         end
      end else begin : g_walk_all
         always_comb begin
            need_walk = xlat_on;
            local_pa  = va;
         end
      end
   endgenerate
endmodule

// File: rtl/xlat_fault_regs.sv
module xlat_fault_regs #(
   parameter int VA_W   = 32,
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [CODE_W-1:0] code,
   input  logic [VA_W-1:0]   va,
   output logic [CODE_W-1:0] status,
   output logic [VA_W-1:0]   addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         addr   <= '0;
      end else if (capture) begin
         status <= code;
         addr   <= va;
      end
   end
endmodule

// File: rtl/xlat_ctl.sv
module xlat_ctl
   import xlat_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int CODE_W    = 8,
   parameter int PAGE_BITS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   input  logic              need_walk,
   input  logic [VA_W-1:0]   local_pa,
   output logic              busy,
   output logic              walk_go,
   output logic [VA_W-1:0]   walk_va,
   output logic [1:0]        walk_kind,
   output logic              walk_user,
   input  logic              wrsp_valid,
   input  logic [CODE_W-1:0] wrsp_code,
   input  logic [VA_W-1:0]   wrsp_pa,
   input  logic [PERM_W-1:0] wrsp_perm,
   input  logic              wrsp_big,
   output logic              fill_valid,
   output logic [VA_W-1:0]   fill_va,
   output logic [VA_W-1:0]   fill_pa,
   output logic [PERM_W-1:0] fill_perm,
   output logic              fill_big,
   output logic              flt_valid,
   output logic              flt_itrap,
   output logic              capture
);
   localparam logic [VA_W-1:0] PG_MASK =
      {{(VA_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

   state_e          state;
   logic [VA_W-1:0] held_va;
   logic [VA_W-1:0] held_pa;
   logic [1:0]      held_kind;
   logic            held_user;
   logic            accept;
   logic            answer;

   assign busy      = (state != ST_IDLE);
   assign accept    = req_valid && !busy;
   assign answer    = (state == ST_WALK) && wrsp_valid;
   assign capture   = answer && (wrsp_code != '0);
   assign walk_va   = held_va;
   assign walk_kind = held_kind;
   assign walk_user = held_user;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         held_va    <= '0;
         held_pa    <= '0;
         held_kind  <= KIND_LOAD;
         held_user  <= 1'b0;
         walk_go    <= 1'b0;
         fill_valid <= 1'b0;
         fill_va    <= '0;
         fill_pa    <= '0;
         fill_perm  <= '0;
         fill_big   <= 1'b0;
         flt_valid  <= 1'b0;
         flt_itrap  <= 1'b0;
      end else begin
         walk_go    <= 1'b0;
         fill_valid <= 1'b0;
         flt_valid  <= 1'b0;
         case (state)
            ST_IDLE: if (accept) begin
               held_va   <= req_va;
               held_pa   <= local_pa;
               held_kind <= req_kind;
               held_user <= req_user;
               walk_go   <= need_walk;
               state     <= need_walk ? ST_WALK : ST_LOCAL;
            end
            ST_LOCAL: begin
               fill_valid <= 1'b1;
               fill_va    <= held_va & PG_MASK;
               fill_pa    <= held_pa & PG_MASK;
               fill_perm  <= PERM_RWX;
               fill_big   <= 1'b0;
               state      <= ST_IDLE;
            end
            ST_WALK: if (answer) begin
               if (wrsp_code != '0) begin
                  flt_valid <= 1'b1;
                  flt_itrap <= (held_kind == KIND_FETCH);
               end else begin
                  fill_valid <= 1'b1;
                  fill_va    <= held_va & PG_MASK;
                  fill_pa    <= wrsp_pa & PG_MASK;
                  fill_perm  <= wrsp_perm;
                  fill_big   <= wrsp_big;
               end
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xlat_front.sv
module xlat_front
   import xlat_pkg::*;
#(
   parameter int VA_W         = 32,
   parameter int CODE_W       = 8,
   parameter int PAGE_BITS    = 12,
   parameter bit LOW_REDIRECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlat_on,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   output logic              busy,
   output logic              walk_go,
   output logic [VA_W-1:0]   walk_va,
   output logic [1:0]        walk_kind,
   output logic              walk_user,
   input  logic              wrsp_valid,
   input  logic [CODE_W-1:0] wrsp_code,
   input  logic [VA_W-1:0]   wrsp_pa,
   input  logic [2:0]        wrsp_perm,
   input  logic              wrsp_big,
   output logic              fill_valid,
   output logic [VA_W-1:0]   fill_va,
   output logic [VA_W-1:0]   fill_pa,
   output logic [2:0]        fill_perm,
   output logic              fill_big,
   output logic              flt_valid,
   output logic              flt_itrap,
   output logic [CODE_W-1:0] flt_status,
   output logic [VA_W-1:0]   flt_addr
);
   initial begin
      if (VA_W < PAGE_BITS + 2)
         $error("xlat_front: VA_W must exceed PAGE_BITS by at least 2");
      if (CODE_W < 1)
         $error("xlat_front: CODE_W must be positive");
   end

   logic            need_walk;
   logic [VA_W-1:0] local_pa;
   logic            capture;

   xlat_route #(.VA_W(VA_W), .LOW_REDIRECT(LOW_REDIRECT)) u_route (
      .xlat_on  (xlat_on),
      .va       (req_va),
      .user     (req_user),
      .need_walk(need_walk),
      .local_pa (local_pa)
   );

   xlat_ctl #(.VA_W(VA_W), .CODE_W(CODE_W), .PAGE_BITS(PAGE_BITS)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_va    (req_va),
      .req_kind  (req_kind),
      .req_user  (req_user),
      .need_walk (need_walk),
      .local_pa  (local_pa),
      .busy      (busy),
      .walk_go   (walk_go),
      .walk_va   (walk_va),
      .walk_kind (walk_kind),
      .walk_user (walk_user),
      .wrsp_valid(wrsp_valid),
      .wrsp_code (wrsp_code),
      .wrsp_pa   (wrsp_pa),
      .wrsp_perm (wrsp_perm),
      .wrsp_big  (wrsp_big),
      .fill_valid(fill_valid),
      .fill_va   (fill_va),
      .fill_pa   (fill_pa),
      .fill_perm (fill_perm),
      .fill_big  (fill_big),
      .flt_valid (flt_valid),
      .flt_itrap (flt_itrap),
      .capture   (capture)
   );

   xlat_fault_regs #(.VA_W(VA_W), .CODE_W(CODE_W)) u_fregs (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(capture),
      .code   (wrsp_code),
      .va     (walk_va),
      .status (flt_status),
      .addr   (flt_addr)
   );
endmodule

// File: rtl/xlat_front_chk.sv
module xlat_front_chk #(
   parameter int VA_W      = 32,
   parameter int CODE_W    = 8,
   parameter int PAGE_BITS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              walk_go,
   input logic              fill_valid,
   input logic [VA_W-1:0]   fill_va,
   input logic [VA_W-1:0]   fill_pa,
   input logic              flt_valid,
   input logic [CODE_W-1:0] flt_status,
   input logic [VA_W-1:0]   flt_addr
);
   assert_fill_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && flt_valid));
   assert_fill_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> !fill_valid);
   assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |=> !flt_valid);
   assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (fill_va[PAGE_BITS-1:0] == '0 && fill_pa[PAGE_BITS-1:0] == '0));
   assert_fault_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |-> (flt_status != '0));
   assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flt_status) |-> flt_valid);
   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flt_addr) |-> flt_valid);
   assert_walk_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      walk_go |-> busy);
   assert_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid || flt_valid) |-> !busy);
   assert_walk_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      walk_go |=> !walk_go);
endmodule

bind xlat_front xlat_front_chk #(.VA_W(VA_W), .CODE_W(CODE_W), .PAGE_BITS(PAGE_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .walk_go   (walk_go),
   .fill_valid(fill_valid),
   .fill_va   (fill_va),
   .fill_pa   (fill_pa),
   .flt_valid (flt_valid),
   .flt_status(flt_status),
   .flt_addr  (flt_addr)
);

// File: tb/tb_xlat_front.sv
`timescale 1ns/1ps
module tb_xlat_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_on = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic        busy, walk_go, walk_user;
   logic [31:0] walk_va;
   logic [1:0]  walk_kind;
   logic        wrsp_valid = 1'b0;
   logic [7:0]  wrsp_code = '0;
   logic [31:0] wrsp_pa = '0;
   logic [2:0]  wrsp_perm = '0;
   logic        wrsp_big = 1'b0;
   logic        fill_valid, fill_big, flt_valid, flt_itrap;
   logic [31:0] fill_va, fill_pa, flt_addr;
   logic [2:0]  fill_perm;
   logic [7:0]  flt_status;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xlat_front dut (.*);

   // on, user, kind, va, code, rsp_pa, rsp_perm, rsp_big, exp_walk, exp_pa, exp_perm, exp_big
   typedef struct packed {
      logic        on;
      logic        user;
      logic [1:0]  kind;
      logic [31:0] va;
      logic [7:0]  code;
      logic [31:0] rpa;
      logic [2:0]  rperm;
      logic        rbig;
      logic        ewalk;
      logic [31:0] epa;
      logic [2:0]  eperm;
      logic        ebig;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,2'd0,32'h1234_5678,8'h00,32'h0,3'd0,1'b0,1'b0,32'h1234_5000,3'd7,1'b0},
      '{1'b0,1'b0,2'd2,32'h8000_0fff,8'h00,32'h0,3'd0,1'b0,1'b0,32'h8000_0000,3'd7,1'b0},
      '{1'b1,1'b0,2'd1,32'h00ab_cdef,8'h00,32'h0,3'd0,1'b0,1'b0,32'h80ab_c000,3'd7,1'b0},
      '{1'b1,1'b0,2'd0,32'h8000_1234,8'h00,32'h0040_0abc,3'd3,1'b0,1'b1,32'h0040_0000,3'd3,1'b0},
      '{1'b1,1'b1,2'd2,32'h0001_2fff,8'h00,32'h1fc0_0fff,3'd5,1'b1,1'b1,32'h1fc0_0000,3'd5,1'b1},
      '{1'b1,1'b1,2'd0,32'h4000_0010,8'h11,32'h0,3'd0,1'b0,1'b1,32'h0,3'd0,1'b0},
      '{1'b1,1'b1,2'd2,32'h0000_2004,8'h13,32'h0,3'd0,1'b0,1'b1,32'h0,3'd0,1'b0},
      '{1'b1,1'b0,2'd1,32'hffff_f004,8'h0b,32'h0,3'd0,1'b0,1'b1,32'h0,3'd0,1'b0},
      '{1'b1,1'b1,2'd1,32'h8765_4321,8'h00,32'hdead_beef,3'd2,1'b0,1'b1,32'hdead_b000,3'd2,1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic on, input logic user, input logic [1:0] kind,
                       input logic [31:0] va);
      xlat_on   = on;
      req_user  = user;
      req_kind  = kind;
      req_va    = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic answer(input logic [7:0] code, input logic [31:0] pa,
                         input logic [2:0] perm, input logic big);
      wrsp_code  = code;
      wrsp_pa    = pa;
      wrsp_perm  = perm;
      wrsp_big   = big;
      wrsp_valid = 1'b1;
      @(negedge clk);
      wrsp_valid = 1'b0;
   endtask

   logic [7:0]  exp_st;
   logic [31:0] exp_ad;

   initial begin
      exp_st = '0;
      exp_ad = '0;
      repeat (3) @(negedge clk);
      // R7 R8 R9 reset state
      chk("R8 reset busy", {31'b0, busy}, 32'd0);
      chk("R9 reset fill", {31'b0, fill_valid}, 32'd0);
      chk("R9 reset fault", {31'b0, flt_valid}, 32'd0);
      chk("R7 reset status", {24'b0, flt_status}, 32'd0);
      chk("R7 reset addr", flt_addr, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         send(VECS[i].on, VECS[i].user, VECS[i].kind, VECS[i].va);
         chk("R8 busy after accept", {31'b0, busy}, 32'd1);
         chk("R2 walk start", {31'b0, walk_go}, {31'b0, VECS[i].ewalk});
         if (VECS[i].ewalk) begin
            chk("R2 walk va", walk_va, VECS[i].va);
            chk("R2 walk kind", {30'b0, walk_kind}, {30'b0, VECS[i].kind});
            chk("R2 walk user", {31'b0, walk_user}, {31'b0, VECS[i].user});
            answer(VECS[i].code, VECS[i].rpa, VECS[i].rperm, VECS[i].rbig);
         end else begin
            @(negedge clk);
         end
         chk("R8 idle at pulse", {31'b0, busy}, 32'd0);
         if (VECS[i].ewalk && VECS[i].code != 8'h00) begin
            exp_st = VECS[i].code;
            exp_ad = VECS[i].va;
            chk("R5 fault pulse", {31'b0, flt_valid}, 32'd1);
            chk("R5 no fill", {31'b0, fill_valid}, 32'd0);
            chk("R6 trap kind", {31'b0, flt_itrap}, {31'b0, VECS[i].kind == 2'd2});
         end else begin
            chk("R1 R3 R4 fill pulse", {31'b0, fill_valid}, 32'd1);
            chk("R9 no fault", {31'b0, flt_valid}, 32'd0);
            chk("R1 R3 R4 fill va", fill_va, VECS[i].va & 32'hffff_f000);
            chk("R1 R3 R4 fill pa", fill_pa, VECS[i].epa);
            chk("R1 R3 R4 perm", {29'b0, fill_perm}, {29'b0, VECS[i].eperm});
            chk("R1 R3 R4 size", {31'b0, fill_big}, {31'b0, VECS[i].ebig});
         end
         chk("R5 R7 status", {24'b0, flt_status}, {24'b0, exp_st});
         chk("R5 R7 addr", flt_addr, exp_ad);
         @(negedge clk);
         chk("R9 pulse ends", {30'b0, fill_valid, flt_valid}, 32'd0);
      end

      // R8: request held during a walk is ignored
      send(1'b1, 1'b1, 2'd0, 32'h0000_5000);
      send(1'b0, 1'b0, 2'd1, 32'h0bad_0000);
      chk("R8 busy held", {31'b0, busy}, 32'd1);
      chk("R8 no second walk", {31'b0, walk_go}, 32'd0);
      chk("R8 no fill while busy", {31'b0, fill_valid}, 32'd0);
      chk("R8 walk va kept", walk_va, 32'h0000_5000);
      answer(8'h00, 32'h0022_2000, 3'd1, 1'b0);
      chk("R8 original fill", fill_pa, 32'h0022_2000);
      chk("R7 status held after success", {24'b0, flt_status}, {24'b0, exp_st});
      @(negedge clk);
      chk("R9 single pulse", {31'b0, fill_valid}, 32'd0);

      // R10: stray walker answer while idle
      answer(8'h05, 32'h1111_1111, 3'd7, 1'b1);
      chk("R10 no fault", {31'b0, flt_valid}, 32'd0);
      chk("R10 no fill", {31'b0, fill_valid}, 32'd0);
      chk("R10 status kept", {24'b0, flt_status}, {24'b0, exp_st});
      chk("R10 addr kept", flt_addr, exp_ad);
      chk("R10 not busy", {31'b0, busy}, 32'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule